// File: doc/BRIEF.md
# Host Bus 48-Bit Word Packer

This block joins a narrow host bus to a 48-bit internal word path. On downloads it gathers successive host transfers into complete 48-bit words and presents each finished word with a one-cycle strobe. On uploads it takes 48-bit words from the internal side and hands them out piece by piece, one piece per host transfer.

There are two host widths. A 32-bit host moves two 48-bit words in three transfers. A 16-bit host moves one 48-bit word in three transfers, and an order input picks whether the high or the low piece goes first. A 40-bit extended-precision value travels through the same 48-bit path unchanged.

A two-bit status output reports the position within the current three-transfer sequence. Changing the configuration abandons any partly packed word and restarts the sequence.

Top module: `hbus_word_packer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `pack_stat` to 0 and `word_valid` to 0, and discards any partly packed word.
- R2: In 32-bit mode (`wide_mode`=1), downloads use this layout. `host_wr[31:16]` carries internal lines 47-32 and `host_wr[15:0]` carries lines 31-16. Transfer 1 carries {A[47:32], A[31:16]}. Transfer 2 carries {B[15:0], A[15:0]}. Transfer 3 carries {B[47:32], B[31:16]}. Word A is presented after transfer 2 and word B after transfer 3. Each word appears on `word_data` with `word_valid` high for exactly the one cycle after the edge that accepted the completing transfer.
- R3: In 16-bit mode (`wide_mode`=0) with `hi_first`=1, a download takes exactly three transfers on `host_wr[15:0]`. They carry bits 47:32, then 31:16, then 15:0. `host_wr[31:16]` is ignored.
- R4: In 16-bit mode with `hi_first`=0, the three download transfers carry bits 15:0, then 31:16, then 47:32.
- R5: `hi_first` has no effect in 32-bit mode. The result is the same for both values, and toggling it there does not restart the sequence.
- R6: `pack_stat` equals the number of transfers accepted so far in the current sequence (0, 1 or 2). It returns to 0 after the third transfer and never shows 3.
- R7: In 32-bit mode with `upload`=1, `host_rd` shows the R2 layout for the transfer in progress, combinationally. Word A is sampled from `core_word` during transfer 1 and word B during transfer 2. `core_ack` is high in exactly those two transfer cycles.
- R8: In 16-bit mode with `upload`=1, `host_rd[15:0]` shows the piece for the transfer in progress, in the R3/R4 order, and `host_rd[31:16]` is 0. The word is sampled from `core_word` during transfer 1, which is the only cycle in which `core_ack` is high.
- R9: A cycle in which `wide_mode` or `upload` differs from the previous cycle, or in which `hi_first` differs while in 16-bit mode, is a configuration change. In that cycle a transfer is dropped (no `core_ack`), `pack_stat` goes to 0, and the partly packed word is discarded.
- R10: A 40-bit value placed in bits 39:0, with bits 47:40 zero, passes through download and upload unchanged.
- R11: With `xfer` low and the configuration unchanged, `pack_stat` holds, `word_valid` stays 0 and `core_ack` stays 0. `word_valid` never rises while uploading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | 1: 32-bit host, 0: 16-bit host |
| hi_first | input | 1 | 16-bit mode piece order: 1 high first, 0 low first |
| upload | input | 1 | 1: internal to host, 0: host to internal |
| xfer | input | 1 | One host transfer this cycle |
| host_wr | input | 32 | Host data for downloads |
| host_rd | output | 32 | Host data for uploads (combinational) |
| core_word | input | 48 | Internal word offered for upload |
| core_ack | output | 1 | `core_word` taken this cycle |
| word_valid | output | 1 | One-cycle strobe: `word_data` holds a finished word |
| word_data | output | 48 | Assembled 48-bit word |
| pack_stat | output | 2 | Transfers accepted in the current sequence |

## Verification
The assertions check on every cycle the properties that follow from sequence and configuration alone:
- the status never reaching 3,
- reset and configuration changes clearing it,
- the status holding while idle,
- acknowledgements occurring only in upload and only at the correct positions,
- the spacing and direction rules for the word strobe.

Only the bench's scenarios can show that the bit fields land in the right places. It sweeps many word patterns through both widths, both orders and both directions. It also shows that a dropped partial word does not leak into the next word, and that a 40-bit value survives a round trip.

// File: rtl/hbus_word_packer.sv
module hbus_word_packer (
  input  logic        clk,
  input  logic        rst,
  input  logic        wide_mode,
  input  logic        hi_first,
  input  logic        upload,
  input  logic        xfer,
  input  logic [31:0] host_wr,
  output logic [31:0] host_rd,
  input  logic [47:0] core_word,
  output logic        core_ack,
  output logic        word_valid,
  output logic [47:0] word_data,
  output logic [1:0]  pack_stat
);

  logic [1:0]  seq;
  logic        wide_q, hf_q, up_q;
  logic [47:0] acc;
  logic [15:0] spare;
  logic        cfg_chg, take, last, need_word;

  assign cfg_chg   = (wide_mode != wide_q) || (upload != up_q) ||
                     (!wide_mode && (hi_first != hf_q));
  assign take      = xfer && !cfg_chg;
  assign last      = (seq == 2'd2);
  assign need_word = (seq == 2'd0) || (wide_mode && seq == 2'd1);
  assign core_ack  = take && upload && need_word;
  assign pack_stat = seq;

  always_comb begin
    host_rd = 32'd0;
    if (wide_mode) begin
      case (seq)
        2'd0:    host_rd = core_word[47:16];
        2'd1:    host_rd = {core_word[15:0], acc[15:0]};
        default: host_rd = acc[47:16];
      endcase
    end else begin
      case (seq)
        2'd0:    host_rd[15:0] = hi_first ? core_word[47:32] : core_word[15:0];
        2'd1:    host_rd[15:0] = acc[31:16];
        default: host_rd[15:0] = hi_first ? acc[15:0] : acc[47:32];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    wide_q     <= wide_mode;
    hf_q       <= hi_first;
    up_q       <= upload;
    word_valid <= 1'b0;
    if (rst) begin
      seq       <= 2'd0;
      acc       <= 48'd0;
      spare     <= 16'd0;
      word_data <= 48'd0;
    end else if (cfg_chg) begin
      seq <= 2'd0;
    end else if (take) begin
      seq <= last ? 2'd0 : seq + 2'd1;
      if (upload) begin
        if (need_word) acc <= core_word;
      end else if (wide_mode) begin
        case (seq)
          2'd0: acc[47:16] <= host_wr;
          2'd1: begin
            word_data  <= {acc[47:16], host_wr[15:0]};
            word_valid <= 1'b1;
            spare      <= host_wr[31:16];
          end
          default: begin
            word_data  <= {host_wr, spare};
            word_valid <= 1'b1;
          end
        endcase
      end else begin
        case (seq)
          2'd0: begin
            if (hi_first) acc[47:32] <= host_wr[15:0];
            else          acc[15:0]  <= host_wr[15:0];
          end
          2'd1: acc[31:16] <= host_wr[15:0];
          default: begin
            word_valid <= 1'b1;
            word_data  <= hi_first ? {acc[47:16], host_wr[15:0]}
                                   : {host_wr[15:0], acc[31:0]};
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/hbus_word_packer_chk.sv
module hbus_word_packer_chk (
  input logic       clk,
  input logic       rst,
  input logic       wide_mode,
  input logic       hi_first,
  input logic       upload,
  input logic       xfer,
  input logic       core_ack,
  input logic       word_valid,
  input logic [1:0] pack_stat
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (pack_stat == 2'd0 && !word_valid));

  p_stat_range_r6: assert property (@(posedge clk) disable iff (rst)
    pack_stat != 2'd3);

  p_cfg_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (!$stable(wide_mode) || !$stable(upload)) |=> pack_stat == 2'd0);

  p_order_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (!wide_mode && $stable(wide_mode) && !$stable(hi_first)) |=> pack_stat == 2'd0);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!xfer && $stable(wide_mode) && $stable(upload) && $stable(hi_first))
      |=> ($stable(pack_stat) && !word_valid));

  p_ack_dir_r7: assert property (@(posedge clk) disable iff (rst)
    core_ack |-> (upload && xfer && pack_stat != 2'd2));

  p_ack_first_r8: assert property (@(posedge clk) disable iff (rst)
    (core_ack && !wide_mode) |-> pack_stat == 2'd0);

  p_no_word_up_r11: assert property (@(posedge clk) disable iff (rst)
    (upload && $stable(upload)) |=> !word_valid);

  p_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (!wide_mode && word_valid) |=> !word_valid);

endmodule

bind hbus_word_packer hbus_word_packer_chk u_chk (
  .clk(clk), .rst(rst), .wide_mode(wide_mode), .hi_first(hi_first),
  .upload(upload), .xfer(xfer), .core_ack(core_ack),
  .word_valid(word_valid), .pack_stat(pack_stat)
);

// File: tb/hbus_word_packer_bench.sv
`timescale 1ns/1ps
module hbus_word_packer_bench;
  logic        clk = 0, rst = 1, wide_mode = 1, hi_first = 1, upload = 0, xfer = 0;
  logic [31:0] host_wr = 0, host_rd;
  logic [47:0] core_word = 0, word_data;
  logic        core_ack, word_valid;
  logic [1:0]  pack_stat;
  logic [31:0] rd_s;
  logic        ack_s;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hbus_word_packer u_hbus_word_packer (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .hi_first(hi_first),
    .upload(upload), .xfer(xfer), .host_wr(host_wr), .host_rd(host_rd),
    .core_word(core_word), .core_ack(core_ack), .word_valid(word_valid),
    .word_data(word_data), .pack_stat(pack_stat)
  );

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit x, input logic [31:0] wr, input logic [47:0] cw);
    @(negedge clk);
    xfer = x; host_wr = wr; core_word = cw;
    #1;
    rd_s = host_rd; ack_s = core_ack;
    @(posedge clk);
    #1;
    xfer = 0;
  endtask

  task automatic setcfg(input bit w, input bit h, input bit u);
    @(negedge clk);
    wide_mode = w; hi_first = h; upload = u; xfer = 0;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [47:0] pat(input int i, input int k);
    logic [15:0] a, b, c;
    a = 16'(i * 965 + k * 7 + 4369);
    b = 16'(i * 2531) ^ 16'(k * 257);
    c = 16'(i * 241 + k * 4112 + 1);
    return {a, b, c};
  endfunction

  function automatic logic [15:0] piece(input logic [47:0] w, input int n, input bit hf);
    int idx = hf ? 2 - n : n;
    return w[idx*16 +: 16];
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 48'd0, 48'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] a, b, v;
    repeat (3) @(posedge clk);
    #1;
    chk(pack_stat == 0 && !word_valid, "R1 reset state", {46'd0, pack_stat}, 48'd0);
    @(negedge clk); rst = 0;

    // R2 R5 R6: 32-bit download sweep, both order values
    for (int i = 0; i < 64; i++) begin
      a = pat(i, 1); b = pat(i, 2);
      @(negedge clk); hi_first = i[0];
      step(1, a[47:16], 0);
      chk(!word_valid, "R2 no word after t1", {47'd0, word_valid}, 48'd0);
      chk(pack_stat == 1, "R6 stat after t1", {46'd0, pack_stat}, 48'd1);
      step(1, {b[15:0], a[15:0]}, 0);
      chk(word_valid && word_data == a, "R2/R5 word A", word_data, a);
      chk(pack_stat == 2, "R6 stat after t2", {46'd0, pack_stat}, 48'd2);
      step(1, b[47:16], 0);
      chk(word_valid && word_data == b, "R2/R5 word B", word_data, b);
      chk(pack_stat == 0, "R6 stat wraps", {46'd0, pack_stat}, 48'd0);
    end

    // R5: toggling order mid-sequence in 32-bit mode does not restart
    a = pat(70, 1); b = pat(70, 2);
    step(1, a[47:16], 0);
    @(negedge clk); hi_first = ~hi_first;
    @(posedge clk); #1;
    chk(pack_stat == 1, "R5 order toggle keeps stat", {46'd0, pack_stat}, 48'd1);
    step(1, {b[15:0], a[15:0]}, 0);
    chk(word_valid && word_data == a, "R5 word after toggle", word_data, a);
    step(1, b[47:16], 0);

    // R3 R4: 16-bit download sweeps, junk in upper half
    for (int h = 0; h < 2; h++) begin
      setcfg(0, h[0], 0);
      for (int i = 0; i < 64; i++) begin
        a = pat(i, 3 + h);
        for (int n = 0; n < 3; n++) begin
          step(1, {16'hDEAD ^ 16'(i), piece(a, n, h[0])}, 0);
          if (n < 2) chk(!word_valid && pack_stat == 2'(n + 1), h ? "R3 partial" : "R4 partial",
                         {46'd0, pack_stat}, 48'(n + 1));
        end
        chk(word_valid && word_data == a, h ? "R3 word" : "R4 word", word_data, a);
      end
    end

    // R7: 32-bit upload
    setcfg(1, 0, 1);
    for (int i = 0; i < 64; i++) begin
      a = pat(i, 5); b = pat(i, 6);
      step(1, 0, a);
      chk(ack_s && rd_s == a[47:16], "R7 t1", {16'd0, rd_s}, {16'd0, a[47:16]});
      step(1, 0, b);
      chk(ack_s && rd_s == {b[15:0], a[15:0]}, "R7 t2", {16'd0, rd_s}, {16'd0, b[15:0], a[15:0]});
      step(1, 0, 48'hBAD0_BAD0_BAD0);
      chk(!ack_s && rd_s == b[47:16], "R7 t3", {16'd0, rd_s}, {16'd0, b[47:16]});
      chk(!word_valid, "R11 no word in upload", {47'd0, word_valid}, 48'd0);
    end

    // R8: 16-bit upload both orders
    for (int h = 0; h < 2; h++) begin
      setcfg(0, h[0], 1);
      for (int i = 0; i < 32; i++) begin
        a = pat(i, 7 + h);
        for (int n = 0; n < 3; n++) begin
          step(1, 0, n == 0 ? a : 48'h5A5A_5A5A_5A5A);
          chk(ack_s == (n == 0) && rd_s == {16'd0, piece(a, n, h[0])}, "R8 piece",
              {15'd0, ack_s, rd_s}, {15'd0, n == 0, 16'd0, piece(a, n, h[0])});
        end
      end
    end

    // R9: order change in 16-bit mode drops the transfer and the partial word
    setcfg(0, 1, 0);
    a = pat(90, 1); b = pat(91, 1);
    step(1, {16'd0, a[47:32]}, 0);
    chk(pack_stat == 1, "R9 partial before change", {46'd0, pack_stat}, 48'd1);
    @(negedge clk); hi_first = 0; xfer = 1; host_wr = {16'd0, a[31:16]};
    @(posedge clk); #1; xfer = 0;
    chk(pack_stat == 0 && !word_valid, "R9 order change clears", {46'd0, pack_stat}, 48'd0);
    for (int n = 0; n < 3; n++) step(1, {16'd0, piece(b, n, 0)}, 0);
    chk(word_valid && word_data == b, "R9 clean word after change", word_data, b);

    // R9: width change discards
    step(1, {16'd0, piece(a, 0, 0)}, 0);
    step(1, {16'd0, piece(a, 1, 0)}, 0);
    setcfg(1, 0, 0);
    chk(pack_stat == 0, "R9 width change clears", {46'd0, pack_stat}, 48'd0);
    step(1, a[47:16], 0); step(1, {b[15:0], a[15:0]}, 0);
    chk(word_valid && word_data == a, "R9 word after width change", word_data, a);
    step(1, b[47:16], 0);

    // R1: reset mid-sequence
    step(1, a[47:16], 0);
    @(negedge clk); rst = 1; @(posedge clk); #1;
    chk(pack_stat == 0 && !word_valid, "R1 reset mid-sequence", {46'd0, pack_stat}, 48'd0);
    @(negedge clk); rst = 0;

    // R11: idle cycles hold the position
    setcfg(0, 1, 0);
    a = pat(95, 2);
    step(1, {16'd0, a[47:32]}, 0);
    repeat (5) @(posedge clk);
    #1;
    chk(pack_stat == 1 && !word_valid, "R11 idle holds", {46'd0, pack_stat}, 48'd1);
    step(1, {16'd0, a[31:16]}, 0);
    step(1, {16'd0, a[15:0]}, 0);
    chk(word_valid && word_data == a, "R11 word after idle", word_data, a);
    @(posedge clk); #1;
    chk(!word_valid, "R11 strobe one cycle", {47'd0, word_valid}, 48'd0);

    // R10: 40-bit value round trip
    v = {8'h00, 40'hA5_1234_5678};
    for (int n = 0; n < 3; n++) step(1, {16'd0, piece(v, n, 1)}, 0);
    chk(word_valid && word_data == v, "R10 40-bit download", word_data, v);
    setcfg(0, 1, 1);
    for (int n = 0; n < 3; n++) begin
      step(1, 0, n == 0 ? v : 48'd0);
      chk(rd_s == {16'd0, piece(v, n, 1)}, "R10 40-bit upload", {16'd0, rd_s}, {32'd0, piece(v, n, 1)});
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule